// File: doc/BRIEF.md
# Two-Stage Serial Clock Generator

This block derives the serial clock of a synchronous serial master from the system clock. The division happens in two stages. The first stage is a prescaler whose divisor is always even. The second stage divides that result by one plus an 8-bit rate value. The shift engine asks for clocking through a run request. While run is held, the block drives the serial clock pin. It also gives two single-cycle strobes: one for the leading edge of each serial period, where data is launched, and one for the trailing edge, where data is captured.

Divisors and polarity are captured only while the block is idle, that is, while it is disabled or run is low. A shift engine can therefore compute a new divisor during a transfer without disturbing the clock that is running. The idle level of the serial clock follows the polarity input. The leading edge is always the first transition away from that level.

Top module: `spi_sck_gen`

## Requirements
- R1: The distance between consecutive leading strobes is P*(1+R) system clock cycles. P is the effective prescale and R is `rate_i`.
- R2: The trailing strobe comes exactly P*(1+R)/2 cycles after a leading strobe, so both phases of the serial clock have equal length.
- R3: Bit 0 of `prescale_i` is ignored, so an odd value acts as the next lower even value. A prescale of 0 acts as 2.
- R4: With prescale 2 and rate 0, the serial clock changes level on every cycle, which gives a period of 2 cycles.
- R5: With prescale 254 and rate 255, the half period is 32512 cycles and the full period is 254*256 cycles.
- R6: The idle level of `sclk_o` equals `cpol_i`. After a leading strobe `sclk_o` is the inverse of the idle level. After a trailing strobe it is back at the idle level.
- R7: While `en_i` or `run_i` is low, `sclk_o` sits at the idle level from the next cycle on and no strobe fires. Both counters restart, so a new run always begins with a full half period.
- R8: Changes to `prescale_i`, `rate_i` or `cpol_i` while running have no effect until the block has been idle for at least one cycle.
- R9: The first leading strobe is seen P*(1+R)/2 cycles after the first clock edge at which `en_i` and `run_i` are both high.
- R10: Each strobe lasts one cycle, and the leading and trailing strobes never fire together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| run_i | input | 1 | Run request from the shift engine |
| prescale_i | input | 8 | Prescale divisor; bit 0 is ignored and 0 acts as 2 |
| rate_i | input | 8 | Second-stage value; the second stage divides by 1 + rate_i |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock pin level |
| lead_o | output | 1 | One-cycle strobe on each leading edge |
| trail_o | output | 1 | One-cycle strobe on each trailing edge |

## Verification
Run is set between clock edges. The first clock edge that sees both `en_i` and `run_i` high counts as cycle 1. The leading strobe and the changed pin level are then due after edge number P*(1+R)/2, because the strobe and the clock phase come from registers loaded at the same edge. The bench samples every output on the falling clock edge and counts falling edges from the run request up to the first strobe. It then counts from each strobe to the next, and compares each count with the half period computed from the prescale and rate values. A drop to idle is checked one cycle later, which is when the registered idle level reaches the pin.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  typedef enum logic {
    PH_REST = 1'b0,
    PH_AWAY = 1'b1
  } sck_phase_e;
endpackage

// File: rtl/spi_sck_prediv.sv
module spi_sck_prediv #(
  parameter int HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q;

  assign tick_o = ~clr_i & (cnt_q == (half_i - HALF_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/spi_sck_ratediv.sv
module spi_sck_ratediv #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              wrap_o
);
  logic [RATE_W-1:0] cnt_q;

  assign wrap_o = tick_i & (cnt_q == rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + RATE_W'(1);
  end
endmodule

// File: rtl/spi_sck_edge.sv
module spi_sck_edge
  import spi_sck_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wrap_i,
  input  logic cpol_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  sck_phase_e phase_q;
  logic       lead_q, trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_REST;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (clr_i) begin
      phase_q <= PH_REST;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      if (wrap_i) phase_q <= (phase_q == PH_REST) ? PH_AWAY : PH_REST;
      lead_q  <= wrap_i & (phase_q == PH_REST);
      trail_q <= wrap_i & (phase_q == PH_AWAY);
    end
  end

  assign sclk_o  = (phase_q == PH_AWAY) ^ cpol_i;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              run_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cpol_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o
);
  localparam int HALF_W = PRE_W - 1;

  logic              clr;
  logic [HALF_W-1:0] half_raw, half_eff, half_q;
  logic [RATE_W-1:0] rate_q;
  logic              cpol_q;
  logic              tick, wrap;

  assign clr      = ~(en_i & run_i);
  // prescale LSB dropped; zero forced to the minimum even divisor
  assign half_raw = prescale_i[PRE_W-1:1];
  assign half_eff = (half_raw == '0) ? HALF_W'(1) : half_raw;

  // settings are sampled only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HALF_W'(1);
      rate_q <= '0;
      cpol_q <= 1'b0;
    end else if (clr) begin
      half_q <= half_eff;
      rate_q <= rate_i;
      cpol_q <= cpol_i;
    end
  end

  spi_sck_prediv #(.HALF_W(HALF_W)) u_prediv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .half_i (half_q),
    .tick_o (tick)
  );

  spi_sck_ratediv #(.RATE_W(RATE_W)) u_ratediv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick),
    .rate_i (rate_q),
    .wrap_o (wrap)
  );

  spi_sck_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .wrap_i  (wrap),
    .cpol_i  (cpol_q),
    .sclk_o  (sclk_o),
    .lead_o  (lead_o),
    .trail_o (trail_o)
  );
endmodule

// File: rtl/spi_sck_gen_chk.sv
module spi_sck_gen_chk #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              run_i,
  input logic [PRE_W-1:0]  prescale_i,
  input logic [RATE_W-1:0] rate_i,
  input logic              cpol_i,
  input logic              sclk_o,
  input logic              lead_o,
  input logic              trail_o
);
  a_r7_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && run_i) |=> (sclk_o == $past(cpol_i)));

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && run_i) |=> (!lead_o && !trail_o));

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  a_r10_lead_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |=> !lead_o);

  a_r10_trail_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |=> !trail_o);

  a_r6_lead_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o != $past(sclk_o)));

  a_r6_trail_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sclk_o != $past(sclk_o)));

  a_r2_edge_has_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sclk_o != $past(sclk_o)) && $past(en_i && run_i)) |-> (lead_o || trail_o));
endmodule

bind spi_sck_gen spi_sck_gen_chk #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_chk (.*);

// File: tb/spi_sck_gen_tb.sv
module spi_sck_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       run_i = 1'b0;
  logic [7:0] prescale_i = 8'd2;
  logic [7:0] rate_i = 8'd0;
  logic       cpol_i = 1'b0;
  logic       sclk_o, lead_o, trail_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  spi_sck_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .run_i(run_i),
    .prescale_i(prescale_i), .rate_i(rate_i), .cpol_i(cpol_i),
    .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input int p, input int r);
    int h = (p >> 1) & 127;
    if (h == 0) h = 1;
    return h * (r + 1);
  endfunction

  // kind: 0 timeout, 1 lead, 2 trail, 3 both
  task automatic wait_strobe(input int limit, output int n, output int kind);
    n = 0; kind = 0;
    while (kind == 0 && n < limit) begin
      @(negedge clk_i);
      n++;
      if (lead_o && trail_o) kind = 3;
      else if (lead_o)       kind = 1;
      else if (trail_o)      kind = 2;
    end
  endtask

  task automatic go_idle(input int p, input int r, input bit c);
    @(negedge clk_i);
    run_i = 1'b0; prescale_i = 8'(p); rate_i = 8'(r); cpol_i = c;
    repeat (2) @(negedge clk_i);
    chk(sclk_o == c, "R6 idle level", sclk_o, c);
  endtask

  task automatic do_pair(input int p, input int r, input bit c, input bit full, input string tag);
    int n, kind, nh, tot;
    nh = half_of(p, r);
    go_idle(p, r, c);
    en_i = 1'b1; run_i = 1'b1;
    wait_strobe(nh + 8, n, kind);
    chk(kind == 1 && n == nh, {tag, " R9 first lead"}, n, nh);
    chk(sclk_o == !c, {tag, " R6 lead level"}, sclk_o, !c);
    tot = n;
    wait_strobe(nh + 8, n, kind);
    chk(kind == 2 && n == nh, {tag, " R2 trail gap"}, n, nh);
    chk(sclk_o == c, {tag, " R6 trail level"}, sclk_o, c);
    if (full) begin
      tot = n;
      wait_strobe(nh + 8, n, kind);
      tot += n;
      chk(kind == 1 && tot == 2 * nh, {tag, " R1 period"}, tot, 2 * nh);
    end else begin
      tot = 2 * n;
      chk(tot == 2 * half_of(p, r), {tag, " R1 period"}, tot, 2 * half_of(p, r));
    end
    run_i = 1'b0;
  endtask

  initial begin
    int n, kind, bad, strobes;
    repeat (3) @(negedge clk_i);
    chk(sclk_o == 1'b0 && !lead_o && !trail_o, "R7 reset state", {sclk_o, lead_o, trail_o}, 0);
    rst_ni = 1'b1;

    // sweep over small prescale and rate values, both polarities
    for (int p = 2; p <= 8; p += 2)
      for (int r = 0; r <= 3; r++)
        for (int c = 0; c <= 1; c++)
          do_pair(p, r, c[0], 1'b1, "sweep");

    do_pair(2, 0, 1'b0, 1'b1, "R4 fastest");
    do_pair(3, 2, 1'b1, 1'b1, "R3 odd prescale");
    do_pair(9, 0, 1'b0, 1'b1, "R3 odd prescale");
    do_pair(0, 1, 1'b0, 1'b1, "R3 zero prescale");
    do_pair(1, 0, 1'b1, 1'b1, "R3 one prescale");
    do_pair(254, 0, 1'b0, 1'b1, "large prescale");
    do_pair(10, 255, 1'b1, 1'b1, "large rate");
    do_pair(254, 255, 1'b0, 1'b0, "R5 slowest");
    chk(half_of(254, 255) * 2 == 254 * 256, "R5 slowest period", half_of(254, 255) * 2, 254 * 256);

    // R7: disabled with run high
    go_idle(4, 0, 1'b1);
    en_i = 1'b0; run_i = 1'b1;
    bad = 0; strobes = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (sclk_o != 1'b1) bad++;
      if (lead_o || trail_o) strobes++;
    end
    chk(bad == 0, "R7 disabled level", bad, 0);
    chk(strobes == 0, "R7 disabled strobes", strobes, 0);

    // R7: drop run mid-period, then restart with a full half period
    en_i = 1'b1;
    go_idle(8, 2, 1'b0);
    run_i = 1'b1;
    wait_strobe(20, n, kind);
    chk(kind == 1 && n == 12, "R7 pre-drop lead", n, 12);
    repeat (5) @(negedge clk_i);
    run_i = 1'b0;
    @(negedge clk_i);
    chk(sclk_o == 1'b0 && !lead_o && !trail_o, "R7 drop to idle", sclk_o, 0);
    run_i = 1'b1;
    wait_strobe(30, n, kind);
    chk(kind == 1 && n == 12, "R7 restart full half", n, 12);

    // R8: settings changed while running are held off
    go_idle(4, 1, 1'b0);
    run_i = 1'b1;
    wait_strobe(20, n, kind);
    chk(kind == 1 && n == 4, "R8 lead before change", n, 4);
    prescale_i = 8'd20; rate_i = 8'd9; cpol_i = 1'b1;
    wait_strobe(20, n, kind);
    chk(kind == 2 && n == 4, "R8 trail holds old rate", n, 4);
    chk(sclk_o == 1'b0, "R8 polarity held", sclk_o, 0);
    @(negedge clk_i);
    run_i = 1'b0;
    @(negedge clk_i);
    run_i = 1'b1;
    wait_strobe(120, n, kind);
    chk(kind == 1 && n == 100, "R8 new rate after idle", n, 100);
    chk(sclk_o == 1'b0, "R8 new polarity after idle", sclk_o, 0);
    run_i = 1'b0;

    // R10: fastest rate, strobes alternate every cycle
    go_idle(2, 0, 1'b0);
    run_i = 1'b1;
    bad = 0;
    @(negedge clk_i);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (lead_o == trail_o) bad++;
      if (lead_o && sclk_o != 1'b1) bad++;
    end
    chk(bad == 0, "R10 R4 alternating strobes", bad, 0);
    run_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule